// File: doc/BRIEF.md
# Aggregated Receive Frame Splitter

A single bulk-receive transfer can hold several Ethernet frames placed end to end, each behind a four-byte header. This block reads such a transfer one byte at a time and hands each frame on as its own packet on a byte stream. Every output beat carries first and last flags and the length of the frame it belongs to. An error flag and a one-cycle error pulse report a transfer that does not parse.

Each header is assembled least-significant byte first. Its low eleven bits give the frame length, and bits 16 to 26 must hold the bitwise complement of that length. Frames of odd length are followed by one pad byte that is skipped. The transfer is only clean if it ends exactly at a frame boundary. A length that exceeds a limit is rejected. The limit is the configured maximum payload plus 18 bytes, which covers the 14-byte Ethernet header and a 4-byte tag. On any error the rest of the transfer, up to its boundary marker, is thrown away.

Top module: `rx_frame_splitter`

## Requirements
- R1: After reset `outValid` and `errPulse` are low and `inReady` is high.
- R2: A header is built from four input bytes, the first one received being bits 7:0. Its frame length is bits 10:0. The following length bytes appear on the output in input order, with `outFirst` on the first beat, `outLast` on the final beat, `outErr` low and `outLen` equal to the length on every beat.
- R3: After a frame of odd length exactly one input byte is skipped before the next header. After an even-length frame no byte is skipped.
- R4: A header with length 0 and a correct complement produces no output beat, and parsing continues with the next header.
- R5: If header bits 26:16 differ from the inverse of bits 10:0, no beat is produced for that header and error code 1 (bad header) is reported.
- R6: A length greater than the sampled maximum plus 18 produces no beat and reports error code 2 (length).
- R7: `cfgMtu` is sampled on the first byte of each transfer. Changes to it later in the same transfer have no effect on that transfer.
- R8: If the transfer ends before a frame's payload is complete, the byte carrying `inLast` is emitted as the frame's final beat with `outLast` and `outErr` high, and error code 2 is reported.
- R9: Error code 3 (bad tail) is reported in two cases: a transfer ends on any byte of a header (1 to 4 bytes left), or it ends on the final byte of an odd-length frame with no pad byte. In the second case that final beat carries `outErr`.
- R10: After an error every byte up to and including the one carrying `inLast` is discarded without output. The next transfer is parsed normally.
- R11: While `outValid` is high and `outReady` low, the output beat stays unchanged and `inReady` is low.
- R12: `errPulse` is high for one cycle, the cycle right after the edge that accepted the offending byte, with `errKind` holding the code. Codes: 1 bad header, 2 length, 3 bad tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inData | input | 8 | Transfer byte |
| inValid | input | 1 | Input byte valid |
| inLast | input | 1 | Byte is the final one of the transfer |
| inReady | output | 1 | Block accepts a byte this cycle |
| cfgMtu | input | 11 | Maximum payload; limit is this plus 18 |
| outData | output | 8 | Frame byte |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Sink accepts the beat |
| outFirst | output | 1 | First beat of a frame |
| outLast | output | 1 | Final beat of a frame |
| outErr | output | 1 | Frame ended by a transfer error |
| outLen | output | 11 | Length of the current frame |
| errPulse | output | 1 | One-cycle error report |
| errKind | output | 2 | Error code while errPulse is high |

## Verification
The hardest cases to reach are those where the transfer boundary falls at one exact byte. It can fall inside a header, on the last byte of an unpadded odd frame, or partway through a payload. Another hard case is a limit change that arrives after a transfer has already started. The stimulus builds each transfer byte by byte from headers with chosen lengths, so the boundary marker lands exactly where each case needs it. A forked process rewrites `cfgMtu` one cycle after the first byte is accepted, and a throttled `outReady` pattern holds beats under backpressure.

// File: rtl/rx_frame_splitter_pkg.sv
package rx_frame_splitter_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_HDR   = 2'd1,
    ERR_LEN   = 2'd2,
    ERR_TRAIL = 2'd3
  } errKind_e;

  typedef enum logic [1:0] {
    ST_HDR,
    ST_PAY,
    ST_PAD,
    ST_DROP
  } parseState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     shiftHdr;
    logic     loadMtu;
    logic     loadLen;
    logic     stepPay;
    logic     emit;
    logic     emitLast;
    logic     emitErr;
    logic     raiseErr;
    errKind_e kind;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic hdrBad;
    logic hdrTooLong;
    logic hdrZero;
    logic payFinal;
    logic lenOdd;
    logic slotFree;
  } dpStatus_t;

endpackage

// File: rtl/rx_frame_splitter_dp.sv
module rx_frame_splitter_dp
  import rx_frame_splitter_pkg::*;
#(
  parameter int LEN_W    = 11,
  parameter int DATA_W   = 8,
  parameter int DEF_MTU  = 1500,
  parameter int OVERHEAD = 18,
  parameter int CMP_OFS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic [LEN_W-1:0]  cfgMtu,
  input  logic              outReady,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         st,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast,
  output logic              outErr,
  output logic [LEN_W-1:0]  outLen,
  output logic              errPulse,
  output logic [1:0]        errKind
);

  localparam int HDR_KEEP = 3 * DATA_W;   // bytes held before the fourth arrives
  localparam int LIM_W    = LEN_W + 1;

  logic [HDR_KEEP-1:0] hdrReg;
  logic [LEN_W-1:0]    mtuReg;
  logic [LEN_W-1:0]    lenReg;
  logic [LEN_W-1:0]    remReg;
  logic                firstPend;

  logic [LEN_W-1:0] hdrLen;
  logic [LEN_W-1:0] hdrInv;
  logic [LIM_W-1:0] limit;

  // the fourth header byte is checked as it arrives, straight from the input
  assign hdrLen = hdrReg[LEN_W-1:0];
  assign hdrInv = LEN_W'({inData, hdrReg[HDR_KEEP-1:CMP_OFS]});
  assign limit  = LIM_W'(mtuReg) + LIM_W'(OVERHEAD);

  always_comb begin
    st.hdrBad     = (hdrInv != ~hdrLen);
    st.hdrTooLong = (LIM_W'(hdrLen) > limit);
    st.hdrZero    = (hdrLen == '0);
    st.payFinal   = (remReg == LEN_W'(1));
    st.lenOdd     = lenReg[0];
    st.slotFree   = !outValid || outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrReg    <= '0;
      mtuReg    <= LEN_W'(DEF_MTU);
      lenReg    <= '0;
      remReg    <= '0;
      firstPend <= 1'b0;
    end else begin
      if (ctl.shiftHdr) hdrReg <= {inData, hdrReg[HDR_KEEP-1:DATA_W]};
      if (ctl.loadMtu)  mtuReg <= cfgMtu;
      if (ctl.loadLen) begin
        lenReg    <= hdrLen;
        remReg    <= hdrLen;
        firstPend <= 1'b1;
      end else begin
        if (ctl.stepPay) remReg <= remReg - LEN_W'(1);
        if (ctl.emit)    firstPend <= 1'b0;
      end
    end
  end

  // single output slot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outFirst <= 1'b0;
      outLast  <= 1'b0;
      outErr   <= 1'b0;
      outLen   <= '0;
    end else if (ctl.emit) begin
      outValid <= 1'b1;
      outData  <= inData;
      outFirst <= firstPend;
      outLast  <= ctl.emitLast;
      outErr   <= ctl.emitErr;
      outLen   <= lenReg;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errPulse <= 1'b0;
      errKind  <= ERR_NONE;
    end else begin
      errPulse <= ctl.raiseErr;
      errKind  <= ctl.raiseErr ? ctl.kind : ERR_NONE;
    end
  end

endmodule

// File: rtl/rx_frame_splitter_ctl.sv
module rx_frame_splitter_ctl
  import rx_frame_splitter_pkg::*;
#(
  parameter int HDR_BYTES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inLast,
  input  dpStatus_t  st,
  output logic       inReady,
  output ctlStrobe_t ctl
);

  localparam int IDX_W = $clog2(HDR_BYTES);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(HDR_BYTES - 1);

  parseState_e      state, nextState;
  logic [IDX_W-1:0] hdrIdx;
  logic             xferStart;
  logic             accept;

  assign inReady = st.slotFree;
  assign accept  = inValid && st.slotFree;

  always_comb begin
    ctl       = '0;
    ctl.kind  = ERR_NONE;
    nextState = state;
    if (accept) begin
      unique case (state)
        ST_HDR: begin
          ctl.shiftHdr = 1'b1;
          ctl.loadMtu  = xferStart;
          if (inLast) begin
            ctl.raiseErr = 1'b1;
            ctl.kind     = ERR_TRAIL;
            nextState    = ST_HDR;
          end else if (hdrIdx == IDX_END) begin
            if (st.hdrBad) begin
              ctl.raiseErr = 1'b1;
              ctl.kind     = ERR_HDR;
              nextState    = ST_DROP;
            end else if (st.hdrTooLong) begin
              ctl.raiseErr = 1'b1;
              ctl.kind     = ERR_LEN;
              nextState    = ST_DROP;
            end else if (!st.hdrZero) begin
              ctl.loadLen = 1'b1;
              nextState   = ST_PAY;
            end
          end
        end
        ST_PAY: begin
          ctl.emit    = 1'b1;
          ctl.stepPay = 1'b1;
          if (st.payFinal) begin
            ctl.emitLast = 1'b1;
            if (inLast) begin
              nextState = ST_HDR;
              if (st.lenOdd) begin
                ctl.emitErr  = 1'b1;
                ctl.raiseErr = 1'b1;
                ctl.kind     = ERR_TRAIL;
              end
            end else begin
              nextState = st.lenOdd ? ST_PAD : ST_HDR;
            end
          end else if (inLast) begin
            ctl.emitLast = 1'b1;
            ctl.emitErr  = 1'b1;
            ctl.raiseErr = 1'b1;
            ctl.kind     = ERR_LEN;
            nextState    = ST_HDR;
          end
        end
        ST_PAD:  nextState = ST_HDR;
        ST_DROP: if (inLast) nextState = ST_HDR;
        default: nextState = ST_HDR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_HDR;
      hdrIdx    <= '0;
      xferStart <= 1'b1;
    end else begin
      state <= nextState;
      if (accept) begin
        xferStart <= inLast;
        if (state == ST_HDR)
          hdrIdx <= (inLast || hdrIdx == IDX_END) ? '0 : hdrIdx + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/rx_frame_splitter.sv
module rx_frame_splitter
  import rx_frame_splitter_pkg::*;
#(
  parameter int LEN_W   = 11,
  parameter int DEF_MTU = 1500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  input  logic [LEN_W-1:0] cfgMtu,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             outFirst,
  output logic             outLast,
  output logic             outErr,
  output logic [LEN_W-1:0] outLen,
  output logic             errPulse,
  output logic [1:0]       errKind
);

  ctlStrobe_t ctl;
  dpStatus_t  st;

  rx_frame_splitter_ctl #(.HDR_BYTES(4)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inLast  (inLast),
    .st      (st),
    .inReady (inReady),
    .ctl     (ctl)
  );

  rx_frame_splitter_dp #(
    .LEN_W   (LEN_W),
    .DATA_W  (8),
    .DEF_MTU (DEF_MTU)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .cfgMtu   (cfgMtu),
    .outReady (outReady),
    .ctl      (ctl),
    .st       (st),
    .outData  (outData),
    .outValid (outValid),
    .outFirst (outFirst),
    .outLast  (outLast),
    .outErr   (outErr),
    .outLen   (outLen),
    .errPulse (errPulse),
    .errKind  (errKind)
  );

endmodule

// File: rtl/rx_frame_splitter_chk.sv
module rx_frame_splitter_chk #(
  parameter int LEN_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [7:0]       outData,
  input logic             outValid,
  input logic             outReady,
  input logic             outFirst,
  input logic             outLast,
  input logic             outErr,
  input logic [LEN_W-1:0] outLen,
  input logic             errPulse,
  input logic [1:0]       errKind
);

  logic [LEN_W:0] beatCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) beatCnt <= '0;
    else if (outValid && outReady) beatCnt <= outLast ? '0 : beatCnt + 1'b1;
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outFirst)
                              && $stable(outLast) && $stable(outErr));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  p_err_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outErr |-> outLast);

  p_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(inValid && inReady) && errKind != 2'd0);

  p_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && outLast && !outErr |-> (beatCnt + 1'b1) == {1'b0, outLen});

  p_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outFirst |-> beatCnt == '0);

  p_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outLen != '0);

endmodule

bind rx_frame_splitter rx_frame_splitter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .outFirst (outFirst),
  .outLast  (outLast),
  .outErr   (outErr),
  .outLen   (outLen),
  .errPulse (errPulse),
  .errKind  (errKind)
);

// File: tb/rx_frame_splitter_bench.sv
module rx_frame_splitter_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inData = '0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic [10:0] cfgMtu = 11'd1500;
  logic [7:0]  outData;
  logic        outValid;
  logic        outReady = 1'b1;
  logic        outFirst;
  logic        outLast;
  logic        outErr;
  logic [10:0] outLen;
  logic        errPulse;
  logic [1:0]  errKind;

  always #10 clk = ~clk;

  rx_frame_splitter u_rx_frame_splitter (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .cfgMtu(cfgMtu), .outData(outData), .outValid(outValid),
    .outReady(outReady), .outFirst(outFirst), .outLast(outLast), .outErr(outErr),
    .outLen(outLen), .errPulse(errPulse), .errKind(errKind)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] txBuf [0:511];
  int txN;
  logic [7:0] expData [0:511];
  logic [2:0] expFlg [0:511];
  int expLen [0:511];
  int expN;
  int expK [0:15];
  int expKN;
  logic [7:0] capData [0:511];
  logic [2:0] capFlg [0:511];
  int capLen [0:511];
  int capN;
  int capK [0:15];
  int capKN;
  int pulseCyc, lastAccCyc, stallViol, stallCnt;
  bit stallMode = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor, sampling between edges
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (outValid && outReady && capN < 512) begin
        capData[capN] = outData;
        capFlg[capN]  = {outFirst, outLast, outErr};
        capLen[capN]  = int'(outLen);
        capN++;
      end
      if (errPulse && capKN < 16) begin
        capK[capKN] = int'(errKind);
        capKN++;
        pulseCyc = cyc;
      end
      if (inValid && inReady && inLast) lastAccCyc = cyc;
      if (outValid && !outReady && inReady) stallViol++;
    end
  end

  always @(posedge clk) begin
    #2;
    stallCnt++;
    outReady = stallMode ? (stallCnt % 3 == 0) : 1'b1;
  end

  task automatic clearAll();
    txN = 0; expN = 0; expKN = 0; capN = 0; capKN = 0;
  endtask

  task automatic putByte(logic [7:0] b);
    txBuf[txN] = b;
    txN++;
  endtask

  task automatic putHdr(int len, bit corrupt);
    logic [31:0] w;
    logic [10:0] l;
    l = 11'(len);
    w = {5'b0, ~l, 5'b0, l};
    if (corrupt) w[16] = ~w[16];
    for (int i = 0; i < 4; i++) putByte(w[8*i +: 8]);
  endtask

  // header, nSend payload bytes, optional pad; expectations if expOut
  task automatic putFrame(int len, int nSend, bit pad, bit expOut, int base);
    putHdr(len, 1'b0);
    for (int i = 0; i < nSend; i++) begin
      putByte(8'(base + i));
      if (expOut) begin
        expData[expN] = 8'(base + i);
        expFlg[expN]  = {i == 0, i == nSend - 1, 1'b0};
        expLen[expN]  = len;
        expN++;
      end
    end
    if (pad && len % 2 == 1) putByte(8'hEE);
  endtask

  task automatic expKind(int k);
    expK[expKN] = k;
    expKN++;
  endtask

  task automatic sendByte(logic [7:0] b, logic l);
    inData = b; inLast = l; inValid = 1'b1;
    forever begin
      @(negedge clk);
      if (inReady) break;
    end
    @(posedge clk);
    #2;
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic sendXfer();
    for (int i = 0; i < txN; i++) sendByte(txBuf[i], i == txN - 1);
    repeat (30) @(posedge clk);
    #2;
  endtask

  task automatic compare(string req);
    int n;
    chk(capN == expN, req, "beat count", capN, expN);
    n = (capN < expN) ? capN : expN;
    for (int i = 0; i < n; i++) begin
      chk(capData[i] == expData[i], req, "data", int'(capData[i]), int'(expData[i]));
      chk(capFlg[i] == expFlg[i], req, "first/last/err", int'(capFlg[i]), int'(expFlg[i]));
      chk(capLen[i] == expLen[i], req, "length", capLen[i], expLen[i]);
    end
    chk(capKN == expKN, req, "error pulse count", capKN, expKN);
    n = (capKN < expKN) ? capKN : expKN;
    for (int i = 0; i < n; i++) chk(capK[i] == expK[i], req, "error code", capK[i], expK[i]);
  endtask

  task automatic t_reset();
    chk(outValid == 1'b0, "R1", "outValid", int'(outValid), 0);
    chk(errPulse == 1'b0, "R1", "errPulse", int'(errPulse), 0);
    chk(inReady == 1'b1, "R1", "inReady", int'(inReady), 1);
  endtask

  task automatic t_basic();
    clearAll();
    putFrame(6, 6, 1, 1, 8'h10);
    putFrame(60, 60, 1, 1, 8'h40);
    putFrame(2, 2, 1, 1, 8'hA0);
    sendXfer();
    compare("R2");
  endtask

  task automatic t_odd();
    clearAll();
    putFrame(5, 5, 1, 1, 8'h01);
    putFrame(1, 1, 1, 1, 8'h30);
    putFrame(7, 7, 1, 1, 8'h50);
    sendXfer();
    compare("R3");
  endtask

  task automatic t_zero();
    clearAll();
    putFrame(4, 4, 1, 1, 8'h11);
    putHdr(0, 1'b0);
    putFrame(3, 3, 1, 1, 8'h22);
    sendXfer();
    compare("R4");
  endtask

  task automatic t_badhdr();
    clearAll();
    putFrame(4, 4, 1, 1, 8'h60);
    putHdr(8, 1'b1);
    for (int i = 0; i < 8; i++) putByte(8'h77);
    putFrame(4, 4, 1, 0, 8'h80);
    expKind(1);
    sendXfer();
    compare("R5");
    clearAll();
    putFrame(6, 6, 1, 1, 8'hC0);
    sendXfer();
    compare("R10");
  endtask

  task automatic t_toolong();
    cfgMtu = 11'd50;
    clearAll();
    putFrame(68, 68, 1, 1, 8'h00);
    putFrame(69, 69, 1, 0, 8'h90);
    putFrame(4, 4, 1, 0, 8'h33);
    expKind(2);
    sendXfer();
    compare("R6");
  endtask

  task automatic t_mtusample();
    cfgMtu = 11'd100;
    clearAll();
    putFrame(60, 60, 1, 1, 8'h05);
    putFrame(118, 118, 1, 1, 8'h70);
    fork
      begin
        do @(negedge clk); while (!(inValid && inReady));
        @(posedge clk);
        #3;
        cfgMtu = 11'd10;
      end
    join_none
    sendXfer();
    compare("R7");
    clearAll();
    putFrame(28, 28, 1, 1, 8'h44);
    putFrame(29, 29, 1, 0, 8'h55);
    expKind(2);
    sendXfer();
    compare("R7");
    cfgMtu = 11'd1500;
  endtask

  task automatic t_overrun();
    clearAll();
    putFrame(10, 6, 0, 1, 8'h20);
    expFlg[expN-1] = 3'b011;
    expKind(2);
    sendXfer();
    compare("R8");
  endtask

  task automatic t_trail();
    clearAll();
    putFrame(4, 4, 1, 1, 8'h12);
    putByte(8'h01); putByte(8'h02); putByte(8'h03);
    expKind(3);
    sendXfer();
    compare("R9");
    chk(pulseCyc == lastAccCyc + 1, "R12", "pulse cycle", pulseCyc, lastAccCyc + 1);
    clearAll();
    putFrame(6, 6, 1, 1, 8'h31);
    putFrame(5, 5, 0, 1, 8'h41);
    expFlg[expN-1] = 3'b011;
    expKind(3);
    sendXfer();
    compare("R9");
    chk(pulseCyc == lastAccCyc + 1, "R12", "pulse cycle", pulseCyc, lastAccCyc + 1);
    clearAll();
    putFrame(2, 2, 1, 1, 8'h51);
    putHdr(2, 1'b0);
    expKind(3);
    sendXfer();
    compare("R9");
  endtask

  task automatic t_stall();
    stallViol = 0;
    stallMode = 1'b1;
    clearAll();
    putFrame(9, 9, 1, 1, 8'h61);
    putFrame(20, 20, 1, 1, 8'h81);
    sendXfer();
    stallMode = 1'b0;
    repeat (3) @(posedge clk);
    compare("R11");
    chk(stallViol == 0, "R11", "input ready while stalled", stallViol, 0);
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pulseCyc = 0; lastAccCyc = 0; stallViol = 0; stallCnt = 0;
    clearAll();
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    @(posedge clk);
    #2;
    t_basic();
    t_odd();
    t_zero();
    t_badhdr();
    t_toolong();
    t_mtusample();
    t_overrun();
    t_trail();
    t_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule